// File: doc/BRIEF.md
# Successive-Integration Conversion Sequencer

This block paces a dual-slope style converter that refines its reading through successive integration and removes offset digitally. A single free-running phase timer, separate from the results counter, steps the analog front end through six phases. The first is a fixed signal integrate. A coarse de-integrate follows. Next comes a times-ten residue amplify, then a finer de-integrate, a second residue amplify, and a finest de-integrate. Each de-integrate feeds the results counter one decade lower than the one before it. Because a de-integrate can only stop on a clock edge, it leaves a small overshoot, and the next amplify phase multiplies that residue before the next, finer pass measures it.

Once the measurement pass is done, the same six phases run again with the inputs shorted together at the same common-mode voltage. The results counter counts in the opposite direction during this pass, so the offset reading is subtracted from the measurement. At the end of the shorted pass a one-cycle pulse tells the results counter to latch its contents for the display. The sequence then starts over.

Every pin is a plain level or pulse. No data stream crosses the block's edge, so there is no valid/ready handshake and nothing can apply back-pressure.

Top module: `si_conv_seq`

## Requirements
- R1: While `rst_n` is low, `sw_int` is 1 and `sw_de`, `sw_amp`, `short_in`, `de_active` and `eoc` are all 0.
- R2: The signal integrate phase (`sw_int`=1) lasts exactly INT_CLKS cycles, and the coarse de-integrate starts in the next cycle.
- R3: A de-integrate phase ends at the first rising edge where `cmp` differs from the value it had at the edge that entered the phase. A change first seen at the d-th sampled edge inside the phase gives a phase of d cycles.
- R4: If `cmp` never changes, a de-integrate phase ends after DE_TIMEOUT cycles.
- R5: Within a pass the phases run in this order: integrate, de-integrate with `digit_sel`=0, amplify, de-integrate with `digit_sel`=1, amplify, de-integrate with `digit_sel`=2. The last de-integrate is followed by the next integrate.
- R6: Each residue amplify phase (`sw_amp`=1) lasts exactly AMP_CLKS cycles.
- R7: Exactly one of `sw_int`, `sw_de` and `sw_amp` is high in every cycle, and `de_active` equals `sw_de`.
- R8: `short_in` is 0 for the whole measurement pass and 1 for the whole shorted-input pass. It changes only on entry to an integrate phase.
- R9: `pol` is sampled on the last cycle of the measurement pass integrate, and `cnt_up` = (not `short_in`) xor that sample. So with `pol`=0 the count goes up in the measurement pass and down in the shorted pass, and `pol`=1 swaps the two. The value of `pol` during the shorted-pass integrate has no effect.
- R10: `eoc` is a one-cycle pulse in the first cycle of the integrate that follows the shorted pass's finest de-integrate, and it is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp | input | 1 | Zero-crossing comparator output |
| pol | input | 1 | Input polarity bit, 1 = negative |
| sw_int | output | 1 | Integrate switch enable |
| sw_de | output | 1 | De-integrate (reference) switch enable |
| sw_amp | output | 1 | Residue times-ten switch enable |
| short_in | output | 1 | Inputs shorted (offset pass) |
| de_active | output | 1 | Results counter enable strobe |
| digit_sel | output | 2 | Decade weight: 0 coarse, 1 finer, 2 finest |
| cnt_up | output | 1 | Results counter direction, 1 = up |
| eoc | output | 1 | Latch pulse at end of conversion |

## Verification
Three full conversions are run, each with a different set of comparator delays across its six de-integrate phases. Some phases flip at the first edge, some flip mid-phase, some flip exactly at the time-out edge and some never flip. These cases separate an exit caused by the comparator from an exit caused by the time-out, and they expose an off-by-one in either path. The polarity bit is set one way during the measurement integrate and the other way during the shorted integrate. This shows whether the count direction follows only the measurement sample, and the conversions use both polarities.

// File: rtl/si_seq_pkg.sv
package si_seq_pkg;
  typedef enum logic [2:0] {
    PH_INT  = 3'd0,
    PH_DE1  = 3'd1,
    PH_AMP1 = 3'd2,
    PH_DE2  = 3'd3,
    PH_AMP2 = 3'd4,
    PH_DE3  = 3'd5
  } phase_e;
endpackage

// File: rtl/si_phase_timer.sv
module si_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/si_cmp_watch.sv
module si_cmp_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cmp,
  output logic flip
);
  logic ref_q;

  // Capture the comparator level at the edge that enters a de-integrate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ref_q <= 1'b0;
    else if (arm) ref_q <= cmp;
  end

  assign flip = cmp ^ ref_q;
endmodule

// File: rtl/si_phase_fsm.sv
module si_phase_fsm
  import si_seq_pkg::*;
#(
  parameter int unsigned INT_CLKS   = 10000,
  parameter int unsigned AMP_CLKS   = 1000,
  parameter int unsigned DE_TIMEOUT = 2000,
  parameter int unsigned CW         = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          flip,
  input  logic          pol,
  output phase_e        phase,
  output logic          short_q,
  output logic          pol_q,
  output logic          advance,
  output logic          arm,
  output logic          eoc
);
  localparam logic [CW-1:0] INT_LIM = CW'(INT_CLKS - 1);
  localparam logic [CW-1:0] AMP_LIM = CW'(AMP_CLKS - 1);
  localparam logic [CW-1:0] DE_LIM  = CW'(DE_TIMEOUT - 1);

  phase_e        nxt;
  logic          is_de;
  logic [CW-1:0] limit;

  always_comb begin
    is_de = (phase == PH_DE1) || (phase == PH_DE2) || (phase == PH_DE3);
    unique case (phase)
      PH_INT:           limit = INT_LIM;
      PH_AMP1, PH_AMP2: limit = AMP_LIM;
      default:          limit = DE_LIM;
    endcase
    advance = (cnt == limit) || (is_de && flip);
    unique case (phase)
      PH_INT:  nxt = PH_DE1;
      PH_DE1:  nxt = PH_AMP1;
      PH_AMP1: nxt = PH_DE2;
      PH_DE2:  nxt = PH_AMP2;
      PH_AMP2: nxt = PH_DE3;
      default: nxt = PH_INT;
    endcase
    arm = advance && ((nxt == PH_DE1) || (nxt == PH_DE2) || (nxt == PH_DE3));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_INT;
      short_q <= 1'b0;
      pol_q   <= 1'b0;
      eoc     <= 1'b0;
    end else begin
      eoc <= advance && (phase == PH_DE3) && short_q;
      if (advance) begin
        phase <= nxt;
        if (phase == PH_DE3)             short_q <= ~short_q;
        if (phase == PH_INT && !short_q) pol_q   <= pol;
      end
    end
  end
endmodule

// File: rtl/si_switch_decode.sv
module si_switch_decode
  import si_seq_pkg::*;
(
  input  phase_e      phase,
  input  logic        short_q,
  input  logic        pol_q,
  output logic        sw_int,
  output logic        sw_de,
  output logic        sw_amp,
  output logic        de_active,
  output logic [1:0]  digit_sel,
  output logic        cnt_up
);
  always_comb begin
    sw_int    = 1'b0;
    sw_de     = 1'b0;
    sw_amp    = 1'b0;
    digit_sel = 2'd0;
    unique case (phase)
      PH_INT:           sw_int = 1'b1;
      PH_AMP1, PH_AMP2: sw_amp = 1'b1;
      PH_DE1:           sw_de  = 1'b1;
      PH_DE2: begin
        sw_de     = 1'b1;
        digit_sel = 2'd1;
      end
      default: begin
        sw_de     = 1'b1;
        digit_sel = 2'd2;
      end
    endcase
    de_active = sw_de;
    cnt_up    = ~short_q ^ pol_q;
  end
endmodule

// File: rtl/si_conv_seq.sv
module si_conv_seq
  import si_seq_pkg::*;
#(
  parameter int unsigned INT_CLKS   = 10000,
  parameter int unsigned AMP_CLKS   = 1000,
  parameter int unsigned DE_TIMEOUT = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp,
  input  logic       pol,
  output logic       sw_int,
  output logic       sw_de,
  output logic       sw_amp,
  output logic       short_in,
  output logic       de_active,
  output logic [1:0] digit_sel,
  output logic       cnt_up,
  output logic       eoc
);
  localparam int unsigned MAX_A = (INT_CLKS > AMP_CLKS) ? INT_CLKS : AMP_CLKS;
  localparam int unsigned MAX_L = (MAX_A > DE_TIMEOUT) ? MAX_A : DE_TIMEOUT;
  localparam int unsigned CW    = $clog2(MAX_L + 1);

  logic [CW-1:0] cnt;
  logic          flip, advance, arm, pol_q;
  phase_e        phase;

  si_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(advance), .cnt(cnt)
  );

  si_cmp_watch u_watch (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cmp(cmp), .flip(flip)
  );

  si_phase_fsm #(
    .INT_CLKS(INT_CLKS), .AMP_CLKS(AMP_CLKS), .DE_TIMEOUT(DE_TIMEOUT), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .flip(flip), .pol(pol),
    .phase(phase), .short_q(short_in), .pol_q(pol_q), .advance(advance),
    .arm(arm), .eoc(eoc)
  );

  si_switch_decode u_dec (
    .phase(phase), .short_q(short_in), .pol_q(pol_q),
    .sw_int(sw_int), .sw_de(sw_de), .sw_amp(sw_amp),
    .de_active(de_active), .digit_sel(digit_sel), .cnt_up(cnt_up)
  );
endmodule

// File: rtl/si_conv_seq_chk.sv
module si_conv_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_int,
  input logic       sw_de,
  input logic       sw_amp,
  input logic       short_in,
  input logic       de_active,
  input logic [1:0] digit_sel,
  input logic       cnt_up,
  input logic       eoc
);
  // R7
  one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_int, sw_de, sw_amp}) == 1 && de_active == sw_de);

  // R5
  digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_de && $past(sw_de)) |-> $stable(digit_sel));

  // R5
  amp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_amp) |-> ($past(sw_de) && $past(digit_sel) != 2'd2));

  // R8
  pass_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(short_in) |-> (sw_int && !$past(sw_int)));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_de && $past(sw_de)) |-> $stable(cnt_up));

  // R10
  eoc_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (sw_int && !short_in && $past(sw_de) && $past(short_in)
             && $past(digit_sel) == 2'd2));
endmodule

bind si_conv_seq si_conv_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_int(sw_int), .sw_de(sw_de), .sw_amp(sw_amp),
  .short_in(short_in), .de_active(de_active), .digit_sel(digit_sel),
  .cnt_up(cnt_up), .eoc(eoc)
);

// File: tb/si_conv_seq_bench.sv
`timescale 1ns/1ps
module si_conv_seq_bench;
  localparam int INT_C = 40;
  localparam int AMP_C = 12;
  localparam int TO_C  = 20;

  logic clk = 1'b0;
  logic rst_n, cmp, pol;
  logic sw_int, sw_de, sw_amp, short_in, de_active, cnt_up, eoc;
  logic [1:0] digit_sel;

  always #2 clk = ~clk;

  si_conv_seq #(.INT_CLKS(INT_C), .AMP_CLKS(AMP_C), .DE_TIMEOUT(TO_C)) u_si_conv_seq (
    .clk(clk), .rst_n(rst_n), .cmp(cmp), .pol(pol),
    .sw_int(sw_int), .sw_de(sw_de), .sw_amp(sw_amp), .short_in(short_in),
    .de_active(de_active), .digit_sel(digit_sel), .cnt_up(cnt_up), .eoc(eoc)
  );

  typedef struct {
    int tag;  // 0 integrate, 1..3 de-integrate by decade, 4 amplify
    bit sh;
    int len;
    bit up;
  } seg_t;

  seg_t exp_q[$];
  int   dly_q[$];
  bit   pol_src[$];
  int   n_chk = 0;
  int   n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int obs_tag();
    if (sw_int) return 0;
    if (sw_amp) return 4;
    return 1 + int'(digit_sel);
  endfunction

  // Driver: one full conversion (measurement pass then shorted pass).
  task automatic push_conv(input bit pm, input int d[6]);
    for (int p = 0; p < 2; p++) begin
      pol_src.push_back(p == 0 ? pm : ~pm);
      exp_q.push_back('{tag: 0, sh: bit'(p), len: INT_C, up: 1'b0});
      for (int k = 0; k < 3; k++) begin
        int dd;
        dd = d[p*3 + k];
        dly_q.push_back(dd);
        exp_q.push_back('{tag: k + 1, sh: bit'(p),
                          len: (dd == 0 || dd >= TO_C) ? TO_C : dd,
                          up: (p == 0) ? ~pm : pm});
        if (k < 2) exp_q.push_back('{tag: 4, sh: bit'(p), len: AMP_C, up: 1'b0});
      end
    end
  endtask

  // Stimulus reactor: drives pol at integrate entry, toggles cmp inside de-integrate.
  initial begin
    int rtag, d, dcnt;
    rtag = -1; d = 0; dcnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        int t;
        t = obs_tag();
        if (t != rtag) begin
          if (t >= 1 && t <= 3) begin
            d = (dly_q.size() != 0) ? dly_q.pop_front() : 0;
            dcnt = 0;
          end
          if (t == 0 && pol_src.size() != 0) pol = pol_src.pop_front();
        end
        rtag = t;
        if (t >= 1 && t <= 3) begin
          dcnt++;
          if (d != 0 && dcnt == d) cmp = ~cmp;
        end
      end
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit started, cur_sh;
    int cur_tag, len;
    started = 1'b0; cur_sh = 1'b0; cur_tag = 0; len = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        int t;
        t = obs_tag();
        chk($countones({sw_int, sw_de, sw_amp}) == 1 && de_active == sw_de,
            "R7 one enable", int'({sw_int, sw_de, sw_amp}), 1);
        if (!started || t != cur_tag) begin
          bit exp_eoc;
          exp_eoc = started && cur_tag == 3 && cur_sh;
          if (started && exp_q.size() != 0) begin
            seg_t e;
            e = exp_q.pop_front();
            if (e.tag == 0) chk(len == e.len, "R2 integrate length", len, e.len);
            else if (e.tag == 4) chk(len == e.len, "R6 amplify length", len, e.len);
            else if (e.len == TO_C) chk(len == e.len, "R4 de-integrate timeout", len, e.len);
            else chk(len == e.len, "R3 de-integrate comparator exit", len, e.len);
            chk(cur_sh == e.sh, "R8 shorted flag over segment", cur_sh, e.sh);
          end
          chk(eoc == exp_eoc, "R10 eoc at segment start", eoc, exp_eoc);
          if (exp_q.size() != 0) begin
            chk(t == exp_q[0].tag, "R5 phase order / digit_sel", t, exp_q[0].tag);
            chk(short_in == exp_q[0].sh, "R8 shorted flag at entry", short_in, exp_q[0].sh);
            if (exp_q[0].tag >= 1 && exp_q[0].tag <= 3)
              chk(cnt_up == exp_q[0].up, "R9 count direction", cnt_up, exp_q[0].up);
          end
          started = 1'b1;
          cur_tag = t;
          cur_sh = short_in;
          len = 1;
        end else begin
          len++;
          chk(!eoc, "R10 eoc mid-segment", eoc, 0);
          chk(short_in == cur_sh, "R8 shorted flag steady", short_in, cur_sh);
        end
      end
    end
  end

  initial begin
    bit done;
    rst_n = 1'b0; cmp = 1'b0; pol = 1'b0;
    push_conv(1'b0, '{5, 3, 1, 7, 2, 19});
    push_conv(1'b1, '{0, 8, 20, 1, 0, 4});
    push_conv(1'b0, '{19, 0, 6, 3, 3, 3});
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(sw_int == 1'b1, "R1 sw_int in reset", sw_int, 1);
    chk({sw_de, sw_amp, de_active} == 3'b000, "R1 switches off in reset",
        int'({sw_de, sw_amp, de_active}), 0);
    chk({short_in, eoc} == 2'b00, "R1 short/eoc in reset", int'({short_in, eoc}), 0);
    @(posedge clk);
    rst_n <= 1'b1;
    done = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (exp_q.size() == 0) begin
        done = 1'b1;
        break;
      end
    end
    if (!done) chk(1'b0, "watchdog expired", exp_q.size(), 0);
    repeat (4) @(posedge clk);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule